// File: doc/BRIEF.md
# Runahead Mode Entry/Exit Controller

This block is the control state machine that moves a simple core model into and out of runahead mode. While the core runs normally, a load that misses the last-level cache raises a trigger with its PC. The controller then pulses a checkpoint-save strobe so that the register file, branch-history register and return-address stack are captured. It also pulses a poison strobe so that the triggering load retires at once with an invalid result, and it raises a runahead-active level that other blocks use to suppress architectural updates.

When the outstanding miss returns, the controller spends exactly one cycle in a restore state. In that cycle it pulses the checkpoint-restore and pipeline-flush strobes and redirects fetch back to the load that caused the episode, so that load executes again rather than being skipped. As an option, the block can also emit an early-fetch pulse a programmable number of cycles before the miss data is expected, so that refetch overlaps the tail of the miss. A trigger that arrives during an episode never starts a nested one.

Top module: `ra_mode_ctrl`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after it, every output is 0: `ra_active`, all strobes, `redirect_valid`, `early_fetch` and `fetch_pc`.
- R2: A `miss_valid` sampled high in normal mode makes `ra_active`, `ckpt_save` and `load_inv` 1 after that edge, and `fetch_pc` equal to the sampled `miss_pc`. `ckpt_save` and `load_inv` stay high for exactly one cycle.
- R3: A `miss_valid` sampled while `ra_active` is 1 (runahead or restore cycle) has no effect. It causes no `ckpt_save`, no `load_inv` and no change of `fetch_pc`, and the controller still returns to normal mode after the restore cycle.
- R4: A `miss_return` sampled in runahead mode makes `ckpt_restore`, `flush` and `redirect_valid` 1 together for exactly one cycle after that edge, with `fetch_pc` equal to the PC of the trigger that opened the episode. This also holds when `miss_valid` is high in the same cycle.
- R5: In the cycle after the restore cycle the controller is back in normal mode: `ra_active`, `redirect_valid`, `flush` and `ckpt_restore` are 0.
- R6: `ra_active` is 1 in every cycle from the cycle after the trigger edge through the restore cycle inclusive.
- R7: A `miss_return` sampled in normal mode is ignored: all outputs stay 0.
- R8: With `early_en` high and `early_lead` (L) and `early_lat` (E) held steady, `early_fetch` is 1 for exactly one cycle, after edge e0+T, where e0 is the trigger edge and T = E−L if E>L, else T = 1. It fires only if `miss_return` has not been sampled at or before edge e0+T. With `early_en` low it stays 0.
- R9: `redirect_valid` is never 1 outside the restore cycle, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Load missed the last-level cache (trigger) |
| miss_pc | input | PC_W | PC of the triggering load |
| miss_return | input | 1 | Outstanding miss data has returned |
| early_en | input | 1 | Enable early refetch |
| early_lead | input | CNT_W | Cycles of refetch lead before expected return |
| early_lat | input | CNT_W | Expected miss latency in cycles from entry |
| ra_active | output | 1 | Runahead episode in progress (incl. restore cycle) |
| ckpt_save | output | 1 | One-cycle checkpoint capture strobe |
| ckpt_restore | output | 1 | One-cycle checkpoint restore strobe |
| load_inv | output | 1 | Triggering load completes with invalid result |
| flush | output | 1 | One-cycle pipeline flush |
| redirect_valid | output | 1 | Fetch redirect to `fetch_pc` |
| fetch_pc | output | PC_W | PC of the load that opened the episode |
| early_fetch | output | 1 | One-cycle early refetch start |

## Verification
A table of episodes varies the trigger PC (including all-ones-aligned and top-bit values), the miss duration from one cycle to twenty, and the early-refetch setting. The early-refetch cases cover a lead that lands mid-episode, a lead larger than the latency (clamped to the first cycle), and a target that coincides with the return (suppressed). These separate a correct target computation from off-by-one, missing-clamp or missing-suppression faults. Directed patterns then put a trigger during runahead, a trigger in the restore cycle, a trigger together with the return, a return in normal mode, and a reset mid-episode. These show whether nesting, priority and the ignore rules are honoured at the ports.

// File: rtl/ra_pkg.sv
`timescale 1ns/1ps
package ra_pkg;
  typedef enum logic [1:0] {
    RA_NORMAL  = 2'd0,
    RA_RUN     = 2'd1,
    RA_RESTORE = 2'd2
  } ra_state_e;

  // Cycle index (from entry) at which early refetch is started.
  function automatic logic [15:0] early_target(input logic [15:0] lat,
                                                input logic [15:0] lead);
    if (lat > lead) early_target = lat - lead;
    else            early_target = 16'd1;
  endfunction
endpackage

// File: rtl/ra_mode_fsm.sv
`timescale 1ns/1ps
module ra_mode_fsm
  import ra_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      miss_valid,
  input  logic      miss_return,
  output ra_state_e state_q,
  output ra_state_e state_d,
  output logic      enter,
  output logic      leave
);
  always_comb begin
    state_d = state_q;
    enter   = 1'b0;
    leave   = 1'b0;
    case (state_q)
      RA_NORMAL: begin
        if (miss_valid) begin
          state_d = RA_RUN;
          enter   = 1'b1;
        end
      end
      RA_RUN: begin
        if (miss_return) begin
          state_d = RA_RESTORE;
          leave   = 1'b1;
        end
      end
      RA_RESTORE: state_d = RA_NORMAL;
      default:    state_d = RA_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= RA_NORMAL;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/ra_pc_latch.sv
`timescale 1ns/1ps
module ra_pc_latch #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap,
  input  logic [PC_W-1:0] pc_in,
  output logic [PC_W-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst)      pc_q <= '0;
    else if (cap) pc_q <= pc_in;
  end
endmodule

// File: rtl/ra_early_timer.sv
`timescale 1ns/1ps
module ra_early_timer
  import ra_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter,
  input  logic             running,
  input  logic             stop,
  input  logic             early_en,
  input  logic [CNT_W-1:0] early_lead,
  input  logic [CNT_W-1:0] early_lat,
  output logic             early_fetch
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;
  logic [15:0]      tgt_wide;
  logic [CNT_W-1:0] tgt;
  logic             hit;

  always_comb begin
    tgt_wide = early_target(16'(early_lat), 16'(early_lead));
    tgt      = tgt_wide[CNT_W-1:0];
    hit      = running && early_en && !fired_q && !stop && (cnt_q == tgt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      fired_q     <= 1'b0;
      early_fetch <= 1'b0;
    end else begin
      early_fetch <= hit;
      if (enter) begin
        cnt_q   <= {{(CNT_W-1){1'b0}}, 1'b1};
        fired_q <= 1'b0;
      end else if (running) begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (hit) fired_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ra_mode_ctrl.sv
`timescale 1ns/1ps
module ra_mode_ctrl
  import ra_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int CNT_W     = 8,
  parameter bit HAS_EARLY = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             miss_valid,
  input  logic [PC_W-1:0]  miss_pc,
  input  logic             miss_return,
  input  logic             early_en,
  input  logic [CNT_W-1:0] early_lead,
  input  logic [CNT_W-1:0] early_lat,
  output logic             ra_active,
  output logic             ckpt_save,
  output logic             ckpt_restore,
  output logic             load_inv,
  output logic             flush,
  output logic             redirect_valid,
  output logic [PC_W-1:0]  fetch_pc,
  output logic             early_fetch
);
  ra_state_e state_q, state_d;
  logic      enter, leave;

  ra_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .miss_valid (miss_valid),
    .miss_return(miss_return),
    .state_q    (state_q),
    .state_d    (state_d),
    .enter      (enter),
    .leave      (leave)
  );

  ra_pc_latch #(.PC_W(PC_W)) u_pc (
    .clk  (clk),
    .rst  (rst),
    .cap  (enter),
    .pc_in(miss_pc),
    .pc_q (fetch_pc)
  );

  generate
    if (HAS_EARLY) begin : g_early
      ra_early_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .enter      (enter),
        .running    (state_q == RA_RUN),
        .stop       (miss_return),
        .early_en   (early_en),
        .early_lead (early_lead),
        .early_lat  (early_lat),
        .early_fetch(early_fetch)
      );
    end else begin : g_no_early
      logic unused_early;
      assign unused_early = early_en ^ (^early_lead) ^ (^early_lat);
      assign early_fetch  = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_active      <= 1'b0;
      ckpt_save      <= 1'b0;
      load_inv       <= 1'b0;
      ckpt_restore   <= 1'b0;
      flush          <= 1'b0;
      redirect_valid <= 1'b0;
    end else begin
      ra_active      <= (state_d != RA_NORMAL);
      ckpt_save      <= enter;
      load_inv       <= enter;
      ckpt_restore   <= leave;
      flush          <= leave;
      redirect_valid <= leave;
    end
  end
endmodule

// File: rtl/ra_mode_ctrl_chk.sv
`timescale 1ns/1ps
module ra_mode_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic miss_valid,
  input logic miss_return,
  input logic ra_active,
  input logic ckpt_save,
  input logic ckpt_restore,
  input logic load_inv,
  input logic flush,
  input logic redirect_valid,
  input logic early_fetch
);
  assert_entry_saves_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ra_active) |-> ckpt_save && load_inv);

  assert_save_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    ckpt_save |=> !ckpt_save);

  assert_no_nest_R3: assert property (@(posedge clk) disable iff (rst)
    (ra_active && miss_valid) |=> !ckpt_save && !load_inv);

  assert_exit_restores_R4: assert property (@(posedge clk) disable iff (rst)
    (ra_active && !redirect_valid && miss_return) |=>
      redirect_valid && flush && ckpt_restore);

  assert_back_to_normal_R5: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> !ra_active && !redirect_valid && !flush);

  assert_active_held_R6: assert property (@(posedge clk) disable iff (rst)
    (ra_active && !redirect_valid && !miss_return) |=> ra_active);

  assert_return_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (!ra_active && miss_return && !miss_valid) |=> !ra_active && !redirect_valid);

  assert_early_in_episode_R8: assert property (@(posedge clk) disable iff (rst)
    early_fetch |-> ra_active && !redirect_valid);

  assert_redirect_in_episode_R9: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> ra_active);

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ckpt_save, ckpt_restore}));
endmodule

bind ra_mode_ctrl ra_mode_ctrl_chk u_chk (.*);

// File: tb/ra_mode_ctrl_bench.sv
`timescale 1ns/1ps
module ra_mode_ctrl_bench;
  localparam int PC_W  = 32;
  localparam int CNT_W = 8;
  localparam int NV    = 6;

  // Episode table: trigger PC, cycles until return, early enable, lead, latency
  localparam logic [31:0] V_PC   [NV] = '{32'h0000_0400, 32'h0000_1000, 32'h0000_2040,
                                          32'h0000_3000, 32'hFFFF_FFFC, 32'h8000_0000};
  localparam int          V_GAP  [NV] = '{5, 10, 4, 6, 1, 20};
  localparam bit          V_EN   [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam int          V_LEAD [NV] = '{2, 3, 0, 9, 0, 5};
  localparam int          V_LAT  [NV] = '{5, 10, 4, 6, 3, 12};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             miss_valid = 1'b0;
  logic [PC_W-1:0]  miss_pc = '0;
  logic             miss_return = 1'b0;
  logic             early_en = 1'b0;
  logic [CNT_W-1:0] early_lead = '0;
  logic [CNT_W-1:0] early_lat = '0;
  logic             ra_active, ckpt_save, ckpt_restore, load_inv, flush;
  logic             redirect_valid, early_fetch;
  logic [PC_W-1:0]  fetch_pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ra_mode_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W)) u_ra_mode_ctrl (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " ra_active"}, 64'(ra_active), 64'd0);
    chk({tag, " strobes"}, 64'({ckpt_save, ckpt_restore, load_inv, flush}), 64'd0);
    chk({tag, " redirect"}, 64'(redirect_valid), 64'd0);
    chk({tag, " early"}, 64'(early_fetch), 64'd0);
  endtask

  task automatic trigger(input logic [31:0] pc);
    miss_valid = 1'b1;
    miss_pc    = pc;
    tick();
    miss_valid = 1'b0;
    miss_pc    = 32'hDEAD_BEEF;
  endtask

  initial begin
    repeat (3) tick();
    chk_idle("R1 in reset");
    rst = 1'b0;
    tick();
    chk_idle("R1 after reset");
    chk("R1 fetch_pc", 64'(fetch_pc), 64'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      int tgt;
      int fires;
      early_en   = V_EN[i];
      early_lead = CNT_W'(V_LEAD[i]);
      early_lat  = CNT_W'(V_LAT[i]);
      tgt   = (V_LAT[i] > V_LEAD[i]) ? V_LAT[i] - V_LEAD[i] : 1;
      fires = 0;
      trigger(V_PC[i]);
      chk("R2 ra_active", 64'(ra_active), 64'd1);
      chk("R2 save+inv", 64'({ckpt_save, load_inv}), 64'd3);
      chk("R2 fetch_pc", 64'(fetch_pc), 64'(V_PC[i]));
      chk("R9 no redirect at entry", 64'(redirect_valid), 64'd0);
      for (int n = 1; n <= V_GAP[i]; n++) begin
        if (n == V_GAP[i]) miss_return = 1'b1;
        tick();
        miss_return = 1'b0;
        if (early_fetch) fires++;
        if (n < V_GAP[i]) begin
          chk("R6 active", 64'(ra_active), 64'd1);
          chk("R2 save pulse", 64'({ckpt_save, load_inv}), 64'd0);
          chk("R9 no redirect", 64'(redirect_valid), 64'd0);
          chk("R8 early timing", 64'(early_fetch),
              64'(V_EN[i] && (n == tgt)));
        end else begin
          chk("R4 restore/flush/redirect",
              64'({ckpt_restore, flush, redirect_valid}), 64'd7);
          chk("R4 redirect pc", 64'(fetch_pc), 64'(V_PC[i]));
          chk("R6 active in restore", 64'(ra_active), 64'd1);
          chk("R8 early suppressed at return", 64'(early_fetch), 64'd0);
        end
      end
      chk("R8 early count", 64'(fires), 64'(V_EN[i] && (tgt < V_GAP[i])));
      tick();
      chk_idle("R5 back to normal");
    end
    early_en = 1'b0;

    // R7: return while in normal mode
    miss_return = 1'b1;
    tick();
    miss_return = 1'b0;
    chk_idle("R7 return ignored");
    tick();
    chk_idle("R7 still idle");

    // R3: trigger during runahead, then during restore cycle
    trigger(32'h0000_A000);
    tick();
    miss_valid = 1'b1;
    miss_pc    = 32'h0000_B000;
    tick();
    miss_valid = 1'b0;
    chk("R3 no save on nested trigger", 64'({ckpt_save, load_inv}), 64'd0);
    chk("R3 pc kept", 64'(fetch_pc), 64'h0000_A000);
    chk("R3 still active", 64'(ra_active), 64'd1);
    miss_return = 1'b1;
    tick();
    miss_return = 1'b0;
    chk("R4 redirect after nested", 64'(redirect_valid), 64'd1);
    chk("R4 pc after nested", 64'(fetch_pc), 64'h0000_A000);
    miss_valid = 1'b1;
    miss_pc    = 32'h0000_C000;
    tick();
    miss_valid = 1'b0;
    chk_idle("R3 trigger in restore ignored");
    chk("R3 pc unchanged in restore", 64'(fetch_pc), 64'h0000_A000);

    // R4: trigger and return in the same runahead cycle
    trigger(32'h0000_D000);
    tick();
    miss_valid  = 1'b1;
    miss_pc     = 32'h0000_E000;
    miss_return = 1'b1;
    tick();
    miss_valid  = 1'b0;
    miss_return = 1'b0;
    chk("R4 return wins", 64'({ckpt_restore, flush, redirect_valid, ckpt_save}), 64'hE);
    chk("R4 pc on tie", 64'(fetch_pc), 64'h0000_D000);
    tick();
    chk_idle("R5 after tie");

    // R1: reset in the middle of an episode
    early_en   = 1'b1;
    early_lead = 8'd0;
    early_lat  = 8'd3;
    trigger(32'h0000_F000);
    rst = 1'b1;
    tick();
    chk_idle("R1 reset mid-episode");
    rst = 1'b0;
    repeat (4) tick();
    chk_idle("R1 no early after reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule